// File: doc/BRIEF.md
# ADC Sample Byte Packer

This block sits between the acquisition logic and the byte-wide SPI read path. During an acquisition window, the acquisition side writes samples through a write port. Each sample is a 10-bit conversion result, a 2-bit cycle tag and the levels of two digital inputs. The samples go into an internal buffer with a write pointer and a read pointer. A pointer-clear strobe sets both pointers to zero before a new run.

The SPI side pulses `byte_req` each time a byte has finished shifting out. On the next clock edge the block loads the byte that will be shifted next on `byte_out`. While an acquisition runs, the block serves the fixed code 0xAA. Once the acquisition ends, the first byte sent is therefore a leftover 0xAA that the master discards. After it, each sample goes out as a high byte and then a low byte. Bit 7 of each byte tells the two halves apart. The master must track how many samples were captured, because reading past the last written sample is not guarded.

Top module: `adc_byte_packer`

## Requirements
- R1: After reset, `byte_out` is 0xAA and both pointers are zero, so the first request after reset loads the high byte of buffer entry 0.
- R2: In any cycle where `acq_busy` is high, `byte_out` is 0xAA at the next edge. A `byte_req` in such a cycle moves no pointer.
- R3: A high byte is {1, cycle[1:0], pins[1:0], adc[9:7]}, with bit 7 set.
- R4: A low byte is {0, adc[6:0]}, with bit 7 clear.
- R5: For each sample, the high byte is served before the low byte. Samples are served in the order they were written.
- R6: After `acq_busy` falls, `byte_out` still holds 0xAA (the dummy byte). The first request after that loads the high byte of the entry at the read pointer.
- R7: A `byte_req` sampled at a clock edge updates `byte_out` at that same edge. Without a request, `byte_out` holds its value.
- R8: `ptr_clr` sets both pointers to 0 and puts `byte_out` back to 0xAA with the dummy state. A write in the same cycle as `ptr_clr` is dropped.
- R9: The buffer holds DEPTH (1024) samples. Once it is full, the write pointer stays at DEPTH and further writes are dropped.
- R10: The read pointer advances only on the request that follows a low byte. It is not checked against the write pointer: reads past the last written sample return older buffer contents, and the read pointer wraps modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one sample into the buffer |
| wr_adc | input | 10 | Conversion result of the sample |
| wr_cycle | input | 2 | Cycle tag of the sample |
| wr_pins | input | 2 | Levels of the two digital inputs |
| ptr_clr | input | 1 | Clear both pointers and the read state |
| acq_busy | input | 1 | Acquisition in progress |
| byte_req | input | 1 | The byte on byte_out has been taken; load the next one |
| byte_out | output | 8 | Byte that will be shifted out next |

## Verification
A wrong read state, such as a missed toggle between the high and low half, shows at the very next request: bit 7 has the wrong value, or a sample is repeated or skipped. A wrong read pointer shows on the first high byte that follows the fault. A write pointer that wraps when it should saturate stays hidden until the wrapped-over entries are read back. For that reason the bench overfills the buffer, reads all 1024 entries, and then checks that the wrapped read returns the first sample written, not one of the later, dropped writes. Stale reads are checked against a model that keeps earlier contents, so an unexpected clear or overwrite of the buffer would also show.

// File: rtl/adc_pack_pkg.sv
package adc_pack_pkg;

  localparam int ADC_W  = 10;
  localparam int TAG_W  = 2;
  localparam int PIN_W  = 2;
  localparam int WORD_W = TAG_W + PIN_W + ADC_W;
  localparam logic [7:0] BUSY_CODE = 8'hAA;

  typedef struct packed {
    logic [TAG_W-1:0] cyc;
    logic [PIN_W-1:0] pins;
    logic [ADC_W-1:0] adc;
  } sample_t;

  typedef enum logic [1:0] {
    RS_DUMMY = 2'd0,
    RS_HI    = 2'd1,
    RS_LO    = 2'd2
  } rd_state_t;

  function automatic logic [7:0] hi_byte(input sample_t s);
    return {1'b1, s.cyc, s.pins, s.adc[9:7]};
  endfunction

  function automatic logic [7:0] lo_byte(input sample_t s);
    return {1'b0, s.adc[6:0]};
  endfunction

endpackage

// File: rtl/sample_store.sv
module sample_store
  import adc_pack_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_en,
  input  sample_t wr_word,
  input  logic    ptr_clr,
  input  logic    rd_step,
  output sample_t cur_word,
  output sample_t nxt_word
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;
  localparam logic [PTR_W-1:0] FULL_AT = PTR_W'(DEPTH);

  sample_t mem [DEPTH];

  logic [PTR_W-1:0]  wr_ptr;
  logic [ADDR_W-1:0] rd_ptr;
  logic [ADDR_W-1:0] rd_next;
  logic              wr_full;
  logic              wr_accept;

  assign wr_full   = (wr_ptr == FULL_AT);
  assign wr_accept = wr_en && !wr_full && !ptr_clr;
  assign rd_next   = rd_ptr + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (wr_accept) mem[wr_ptr[ADDR_W-1:0]] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ptr_clr) begin
      wr_ptr <= '0;
    end else if (wr_accept) begin
      wr_ptr <= wr_ptr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ptr_clr) begin
      rd_ptr <= '0;
    end else if (rd_step) begin
      rd_ptr <= rd_next;
    end
  end

  assign cur_word = mem[rd_ptr];
  assign nxt_word = mem[rd_next];

  // R9
  wr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= FULL_AT);

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_full && !ptr_clr) |=> (wr_ptr == FULL_AT));

  // R8
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> (wr_ptr == '0 && rd_ptr == '0));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_step && !ptr_clr) |=> $stable(rd_ptr));

endmodule

// File: rtl/byte_sequencer.sv
module byte_sequencer
  import adc_pack_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ptr_clr,
  input  logic       acq_busy,
  input  logic       byte_req,
  input  sample_t    cur_word,
  input  sample_t    nxt_word,
  output logic       rd_step,
  output logic [7:0] byte_out
);

  rd_state_t state;
  logic      hold_off;
  logic      load_evt;

  assign hold_off = acq_busy || ptr_clr;
  assign load_evt = byte_req && !hold_off;
  assign rd_step  = load_evt && (state == RS_LO);

  always_ff @(posedge clk) begin
    if (!rst_n || hold_off) begin
      state    <= RS_DUMMY;
      byte_out <= BUSY_CODE;
    end else if (load_evt) begin
      unique case (state)
        RS_DUMMY: begin
          byte_out <= hi_byte(cur_word);
          state    <= RS_HI;
        end
        RS_HI: begin
          byte_out <= lo_byte(cur_word);
          state    <= RS_LO;
        end
        default: begin
          byte_out <= hi_byte(nxt_word);
          state    <= RS_HI;
        end
      endcase
    end
  end

  // R2
  busy_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_busy |=> (byte_out == BUSY_CODE));

  // R3
  hi_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RS_HI) |-> byte_out[7]);

  // R4
  lo_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RS_LO) |-> !byte_out[7]);

  // R5
  lo_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_step |=> (state == RS_HI));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_req && !hold_off) |=> $stable(byte_out));

endmodule

// File: rtl/adc_byte_packer.sv
module adc_byte_packer
  import adc_pack_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [9:0] wr_adc,
  input  logic [1:0] wr_cycle,
  input  logic [1:0] wr_pins,
  input  logic       ptr_clr,
  input  logic       acq_busy,
  input  logic       byte_req,
  output logic [7:0] byte_out
);

  sample_t wr_word;
  sample_t cur_word;
  sample_t nxt_word;
  logic    rd_step;

  assign wr_word = '{cyc: wr_cycle, pins: wr_pins, adc: wr_adc};

  sample_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_word  (wr_word),
    .ptr_clr  (ptr_clr),
    .rd_step  (rd_step),
    .cur_word (cur_word),
    .nxt_word (nxt_word)
  );

  byte_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_clr  (ptr_clr),
    .acq_busy (acq_busy),
    .byte_req (byte_req),
    .cur_word (cur_word),
    .nxt_word (nxt_word),
    .rd_step  (rd_step),
    .byte_out (byte_out)
  );

endmodule

// File: tb/sim_adc_byte_packer.sv
`timescale 1ns/1ps
module sim_adc_byte_packer;

  localparam int DEPTH = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [9:0] wr_adc = '0;
  logic [1:0] wr_cycle = '0;
  logic [1:0] wr_pins = '0;
  logic       ptr_clr = 1'b0;
  logic       acq_busy = 1'b0;
  logic       byte_req = 1'b0;
  logic [7:0] byte_out;

  adc_byte_packer #(.DEPTH(DEPTH)) u0 (.*);

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model: word = {cycle, pins, adc}
  logic [13:0] mmem [DEPTH];
  int mwr = 0;
  int mrd = 0;
  int mst = 0; // 0 dummy, 1 high served, 2 low served

  function automatic logic [7:0] want_hi(input logic [13:0] w);
    return {1'b1, w[13:12], w[11:10], w[9:7]};
  endfunction
  function automatic logic [7:0] want_lo(input logic [13:0] w);
    return {1'b0, w[6:0]};
  endfunction

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic do_write(input logic [13:0] w);
    wr_en = 1'b1;
    {wr_cycle, wr_pins, wr_adc} = w;
    @(negedge clk);
    wr_en = 1'b0;
    if (mwr < DEPTH) begin
      mmem[mwr] = w;
      mwr++;
    end
  endtask

  task automatic do_clear();
    ptr_clr = 1'b1;
    @(negedge clk);
    ptr_clr = 1'b0;
    mwr = 0; mrd = 0; mst = 0;
    check(byte_out, 8'hAA, "R8 clear restores code");
  endtask

  task automatic do_req();
    logic [7:0] exp;
    string tag;
    byte_req = 1'b1;
    @(negedge clk);
    byte_req = 1'b0;
    if (mst == 0) begin
      exp = want_hi(mmem[mrd]); mst = 1; tag = "R6 R3 first high byte";
    end else if (mst == 1) begin
      exp = want_lo(mmem[mrd]); mst = 2; tag = "R4 R7 low byte";
    end else begin
      mrd = (mrd + 1) % DEPTH;
      exp = want_hi(mmem[mrd]); mst = 1; tag = "R5 R10 next high byte";
    end
    check(byte_out, exp, tag);
  endtask

  task automatic busy_phase(input int n);
    acq_busy = 1'b1;
    for (int i = 0; i < n; i++) begin
      byte_req = $urandom_range(0, 1);
      @(negedge clk);
      check(byte_out, 8'hAA, "R2 busy code");
    end
    byte_req = 1'b0;
    acq_busy = 1'b0;
    mst = 0;
    @(negedge clk);
    check(byte_out, 8'hAA, "R6 dummy byte");
  endtask

  task automatic read_samples(input int n);
    for (int i = 0; i < 2 * n; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        logic [7:0] keep;
        keep = byte_out;
        @(negedge clk);
        check(byte_out, keep, "R7 hold without request");
      end
      do_req();
    end
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(byte_out, 8'hAA, "R1 reset code");

    // R1: pointers start at zero
    do_write(14'h3A5C);
    do_req();
    do_req();

    // directed: busy blocks pointer moves, then dummy and ordered reads
    do_clear();
    for (int i = 0; i < 6; i++) do_write(14'($urandom()));
    busy_phase(5);
    read_samples(6);

    // directed: format corners
    do_clear();
    do_write(14'h3FFF);
    do_write(14'h0000);
    do_write(14'h2A80);
    do_write(14'h157F);
    busy_phase(2);
    read_samples(4);

    // random rounds
    for (int r = 0; r < 20; r++) begin
      int n;
      n = $urandom_range(1, 40);
      do_clear();
      acq_busy = 1'b1;
      for (int i = 0; i < n; i++) do_write(14'($urandom()));
      busy_phase($urandom_range(1, 4));
      read_samples(n);
    end

    // R10: stale contents past the last written sample
    do_clear();
    for (int i = 0; i < 8; i++) do_write(14'($urandom()));
    do_clear();
    do_write(14'h1234);
    do_write(14'h0ABC);
    busy_phase(1);
    read_samples(5);

    // R8: write in the same cycle as clear is dropped
    do_clear();
    do_write(14'h2222);
    ptr_clr = 1'b1;
    wr_en = 1'b1;
    {wr_cycle, wr_pins, wr_adc} = 14'h3333;
    @(negedge clk);
    ptr_clr = 1'b0;
    wr_en = 1'b0;
    mwr = 0; mrd = 0; mst = 0;
    do_write(14'h1111);
    busy_phase(1);
    read_samples(1);

    // R9: overfill, read all, then wrap to entry 0
    do_clear();
    for (int i = 0; i < DEPTH + 6; i++) do_write(14'($urandom()));
    busy_phase(2);
    read_samples(DEPTH + 1);

    finish_run();
  end

endmodule